// File: doc/BRIEF.md
# Dual-Channel Converter Serial Port Model

This block stands in for the digital serial port of a dual simultaneous-sampling converter. A stimulus source presents two parallel conversion words, one for each channel. When the host pulls chip select low, the block latches both words as the current sample. It then shifts them out on two serial data lines, in step with the host's serial clock. Each data line has its own data bit, and the two lines share an output-enable flag. Outside a frame the enable is low, which marks the lines as released (high impedance).

The port uses a fixed framing. A zero is driven as soon as the frame opens, and a second zero follows on the first falling clock edge. The word then goes out MSB first, one bit per falling edge, with zeros after the LSB. A frame that closes before it receives enough rising clock edges is reported as aborted. A chip-select high time shorter than the acquisition window is reported as a violation. Chip select and serial clock are brought into the system clock domain by synchronizers. The system clock must run at least four times faster than the serial clock.

Top module: `dual_adc_port`

## Requirements
- R1: While chip select (csN) is high, sdoEn is 0 and both sdoA and sdoB are 0 (released).
- R2: Within three system clocks of csN falling, sdoEn becomes 1 and both data lines drive 0.
- R3: The first sclk falling edge of a frame drives 0. Falling edge k, for k from 2 to RES+1, drives bit RES+1-k of the channel word, so the MSB goes out first and the LSB on edge RES+1.
- R4: Every sclk falling edge after edge RES+1 in the same frame drives 0 on both lines.
- R5: sdoA carries only the wordA sample and sdoB carries only the wordB sample, and both lines shift on the same edges.
- R6: If csN rises after fewer than RES+2 sclk rising edges in the frame, frameAbort pulses for one clock. If at least RES+2 rising edges were given, frameAbort stays 0.
- R7: acqViolation pulses for one clock when csN falls less than ACQ_CYCLES system clocks after the previous frame ended. It stays 0 for longer gaps and for the first frame after reset.
- R8: Both words are sampled when csN falls. Changes on wordA and wordB during a frame do not alter the bits shifted in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wordA | input | RES | Channel A conversion word (two's complement) |
| wordB | input | RES | Channel B conversion word (two's complement) |
| csN | input | 1 | Host chip select, active low, asynchronous |
| sclk | input | 1 | Host serial clock, idles high, asynchronous |
| sdoA | output | 1 | Channel A serial data bit |
| sdoB | output | 1 | Channel B serial data bit |
| sdoEn | output | 1 | Output enable for both data lines (0 = high impedance) |
| frameAbort | output | 1 | One-clock pulse when a frame closes early |
| acqViolation | output | 1 | One-clock pulse when the acquisition gap was too short |

## Verification
The hardest cases sit at the rising-edge count boundary: a frame cut off after exactly RES+1 rising edges must abort, and one cut off after exactly RES+2 must not. The acquisition gap has to land on the correct side of ACQ_CYCLES in synchronized time. Directed frames cover these boundaries, with gaps set well inside each band. A mid-frame word change hits every frame and shows that the capture holds. Random frames with random clock counts, gaps and words then cover a mix of padding, early aborts and violations.

// File: rtl/dap_pkg.sv
package dap_pkg;
  typedef struct packed {
    logic frameStart;
    logic frameEnd;
    logic leadZero;
    logic shiftBit;
  } dapStrobes_t;
endpackage

// File: rtl/dap_edge_sync.sv
module dap_edge_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  for (genvar s = 0; s < WIDTH; s++) begin : gSig
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain <= {STAGES{IDLE[s]}};
        prev  <= IDLE[s];
      end else begin
        chain <= {chain[STAGES-2:0], asyncIn[s]};
        prev  <= chain[STAGES-1];
      end
    end
    assign level[s] = chain[STAGES-1];
    assign rise[s]  = !prev && chain[STAGES-1];
    assign fall[s]  = prev && !chain[STAGES-1];

    assert_edge_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
      !(rise[s] && fall[s]));
  end
endmodule

// File: rtl/dap_ctrl.sv
module dap_ctrl
  import dap_pkg::*;
#(
  parameter int RES = 14,
  parameter int ACQ_CYCLES = 40
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csFallN,
  input  logic        csRiseN,
  input  logic        sclkRise,
  input  logic        sclkFall,
  output dapStrobes_t strb,
  output logic        frameAbort,
  output logic        acqViolation
);
  localparam int NEED_RISE = RES + 2;
  localparam int CW = $clog2(NEED_RISE + 1);
  localparam int AW = $clog2(ACQ_CYCLES + 1);

  logic          inFrame;
  logic          haveFrame;
  logic [CW-1:0] fallCnt;
  logic [CW-1:0] riseCnt;
  logic [AW-1:0] highCnt;

  always_comb begin
    strb.frameStart = csFallN;
    strb.frameEnd   = csRiseN && inFrame;
    strb.leadZero   = inFrame && sclkFall && (fallCnt == '0);
    strb.shiftBit   = inFrame && sclkFall && (fallCnt != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame      <= 1'b0;
      haveFrame    <= 1'b0;
      fallCnt      <= '0;
      riseCnt      <= '0;
      highCnt      <= '0;
      frameAbort   <= 1'b0;
      acqViolation <= 1'b0;
    end else begin
      frameAbort   <= 1'b0;
      acqViolation <= 1'b0;
      if (csFallN) begin
        inFrame      <= 1'b1;
        fallCnt      <= '0;
        riseCnt      <= '0;
        acqViolation <= haveFrame && (highCnt < AW'(ACQ_CYCLES));
      end else if (csRiseN && inFrame) begin
        inFrame    <= 1'b0;
        haveFrame  <= 1'b1;
        highCnt    <= '0;
        frameAbort <= (riseCnt < CW'(NEED_RISE));
      end else if (inFrame) begin
        if (sclkFall && fallCnt != CW'(NEED_RISE)) fallCnt <= fallCnt + 1'b1;
        if (sclkRise && riseCnt != CW'(NEED_RISE)) riseCnt <= riseCnt + 1'b1;
      end else if (highCnt != AW'(ACQ_CYCLES)) begin
        highCnt <= highCnt + 1'b1;
      end
    end
  end

  assert_abort_at_close_R6: assert property (@(posedge clk) disable iff (!rstN)
    frameAbort |-> $past(csRiseN));
  assert_viol_at_open_R7: assert property (@(posedge clk) disable iff (!rstN)
    acqViolation |-> $past(csFallN));
  assert_pulses_apart_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({frameAbort, acqViolation}));
endmodule

// File: rtl/dap_datapath.sv
module dap_datapath
  import dap_pkg::*;
#(
  parameter int RES = 14,
  parameter int CHANNELS = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dapStrobes_t                   strb,
  input  logic [CHANNELS-1:0][RES-1:0]  words,
  output logic [CHANNELS-1:0]           sdo,
  output logic                          sdoEn
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sdoEn <= 1'b0;
    else if (strb.frameStart) sdoEn <= 1'b1;
    else if (strb.frameEnd) sdoEn <= 1'b0;
  end

  for (genvar c = 0; c < CHANNELS; c++) begin : gChan
    logic [RES-1:0] shReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shReg  <= '0;
        sdo[c] <= 1'b0;
      end else if (strb.frameStart) begin
        shReg  <= words[c];
        sdo[c] <= 1'b0;
      end else if (strb.frameEnd || strb.leadZero) begin
        sdo[c] <= 1'b0;
      end else if (strb.shiftBit) begin
        sdo[c] <= shReg[RES-1];
        shReg  <= {shReg[RES-2:0], 1'b0};
      end
    end

    assert_open_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
      strb.frameStart |=> (sdoEn && !sdo[c]));
    assert_release_R1: assert property (@(posedge clk) disable iff (!rstN)
      strb.frameEnd |=> (!sdoEn && !sdo[c]));
  end
endmodule

// File: rtl/dual_adc_port.sv
module dual_adc_port #(
  parameter int RES = 14,
  parameter int ACQ_CYCLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [RES-1:0] wordA,
  input  logic [RES-1:0] wordB,
  input  logic           csN,
  input  logic           sclk,
  output logic           sdoA,
  output logic           sdoB,
  output logic           sdoEn,
  output logic           frameAbort,
  output logic           acqViolation
);
  import dap_pkg::*;

  logic [1:0] lvl, riseV, fallV;
  dapStrobes_t strb;
  logic [1:0] sdoV;
  logic [1:0][RES-1:0] words;

  assign words = {wordB, wordA};

  dap_edge_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .IDLE(2'b11)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn({sclk, csN}),
    .level(lvl), .rise(riseV), .fall(fallV)
  );

  dap_ctrl #(.RES(RES), .ACQ_CYCLES(ACQ_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .csFallN(fallV[0]), .csRiseN(riseV[0]),
    .sclkRise(riseV[1]), .sclkFall(fallV[1]),
    .strb(strb), .frameAbort(frameAbort), .acqViolation(acqViolation)
  );

  dap_datapath #(.RES(RES), .CHANNELS(2)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .words(words),
    .sdo(sdoV), .sdoEn(sdoEn)
  );

  assign sdoA = sdoV[0];
  assign sdoB = sdoV[1];

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rstN)
    (lvl[0] && $past(lvl[0]) && $past(lvl[0], 2)) |-> (!sdoEn && !sdoA && !sdoB));
endmodule

// File: tb/dual_adc_port_bench.sv
module dual_adc_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RES = 14;
  localparam int ACQ = 40;
  localparam int HALF = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic [RES-1:0] wordA = '0, wordB = '0;
  logic csN = 1'b1, sclk = 1'b1;
  logic sdoA, sdoB, sdoEn, frameAbort, acqViolation;
  int checks = 0, fails = 0;
  int abortSeen = 0, violSeen = 0;
  bit firstFrame = 1'b1;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_adc_port #(.RES(RES), .ACQ_CYCLES(ACQ)) u_dual_adc_port (
    .clk(clk), .rstN(rstN), .wordA(wordA), .wordB(wordB), .csN(csN), .sclk(sclk),
    .sdoA(sdoA), .sdoB(sdoB), .sdoEn(sdoEn),
    .frameAbort(frameAbort), .acqViolation(acqViolation)
  );

  always @(posedge clk) begin
    if (frameAbort) abortSeen++;
    if (acqViolation) violSeen++;
  end

  function automatic logic expBit(input logic [RES-1:0] w, input int k);
    if (k >= 2 && k <= RES + 1) return w[RES + 1 - k];
    return 1'b0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic runFrame(input logic [RES-1:0] a, input logic [RES-1:0] b,
                          input int nClk, input int gap);
    int a0, v0;
    bit expViol;
    expViol = !firstFrame && (gap + HALF < ACQ);
    wordA = a; wordB = b;
    waitClk(gap);
    v0 = violSeen;
    csN = 1'b0;
    waitClk(HALF);
    chk("R2 enable", int'(sdoEn), 1);
    chk("R2 zeroA", int'(sdoA), 0);
    chk("R2 zeroB", int'(sdoB), 0);
    chk("R7 violation", violSeen - v0, int'(expViol));
    wordA = RES'($urandom); wordB = RES'($urandom);
    for (int k = 1; k <= nClk; k++) begin
      sclk = 1'b0;
      waitClk(HALF);
      chk((k > RES + 1) ? "R4 padA" : "R3 R8 bitA", int'(sdoA), int'(expBit(a, k)));
      chk((k > RES + 1) ? "R4 padB" : "R5 R8 bitB", int'(sdoB), int'(expBit(b, k)));
      sclk = 1'b1;
      waitClk(HALF);
    end
    a0 = abortSeen;
    csN = 1'b1;
    waitClk(HALF);
    chk("R1 released", int'(sdoEn), 0);
    chk("R1 lineA", int'(sdoA), 0);
    chk("R1 lineB", int'(sdoB), 0);
    chk("R6 abort", abortSeen - a0, int'(nClk < RES + 2));
    firstFrame = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    waitClk(3);
    rstN = 1'b1;
    waitClk(3);
    chk("R1 reset enable", int'(sdoEn), 0);
    chk("R1 reset data", int'(sdoA | sdoB), 0);
    chk("R6 reset abort", int'(frameAbort), 0);
    // first frame: short gap but no prior frame -> no violation (R7)
    runFrame(14'h2A5C, 14'h15A3, 16, 2);
    runFrame(14'h2000, 14'h1FFF, 20, 60);   // extremes plus padding (R4)
    runFrame(14'h3FFF, 14'h0000, 16, 6);    // short gap -> R7 violation
    runFrame(14'h1234, 14'h0ABC, 15, 60);   // one rising edge short -> R6 abort
    runFrame(14'h0001, 14'h2001, 5, 60);    // early abort
    runFrame(14'h3A5A, 14'h05A5, 16, 20);   // exact count, short gap
    runFrame(14'h0F0F, 14'h30F0, 0, 60);    // no clocks at all
    for (int i = 0; i < 24; i++) begin
      runFrame(RES'($urandom), RES'($urandom), 8 + int'($urandom_range(0, 16)),
               ($urandom_range(0, 1) == 1) ? 60 + int'($urandom_range(0, 20))
                                           : 2 + int'($urandom_range(0, 20)));
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule